// File: doc/BRIEF.md
# Adjustable Program and Data Memory Decoder

This block decides, for every instruction fetch and every external-data access of a small controller core, whether the cycle is served by on-chip memory or goes out on the multiplexed external bus. Code fetches are compared against a software-selected internal ROM ceiling. A pin held low forces every fetch outside. Data accesses are steered by a two-bit mode that can hide the on-chip 1 kB SRAM entirely, map it at the bottom of the data space, or map it and also reserve the last four data addresses. In that last mode, one reserved address returns a lock-status byte and the other three are fenced off.

Both control fields sit in this block and are written over a simple register bus. The ROM ceiling field is guarded: it only takes a new value when a one-cycle protection qualifier is asserted by an outside timed-write unit. The data mode field takes plain writes. The decode is combinational from the held fields and the current request, so the selects appear in the same cycle as the request.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the ROM ceiling field reads 3'b101 and the data mode field reads 2'b00.
- R2: With ceiling code n in 1..5 and the code pin high, a fetch at address A is internal exactly when A < 512·2^n (limits 03FFh, 07FFh, 0FFFh, 1FFFh, 3FFFh); otherwise it is external.
- R3: Ceiling code 3'b000 sends every fetch to the external bus.
- R4: While the code pin is low, every fetch is external whatever the ceiling code.
- R5: A register write with cfg_sel=0 loads the ceiling field from cfg_wdata[2:0] only when prot_ok is high in the same cycle; without it the field is unchanged.
- R6: A protected write of 3'b110 or 3'b111 to the ceiling field stores 3'b101.
- R7: Data mode 2'b00 sends every data access from 0000h to FFFFh external.
- R8: Data mode 2'b01 maps 0000h–03FFh to the internal SRAM and all higher addresses external.
- R9: Data mode 2'b11 maps 0000h–03FFh internal and 0400h–FFFBh external; a read at FFFCh raises the status select with status_byte = {5'b0, lock_bits}, and no external select.
- R10: In data mode 2'b11 any access to FFFDh–FFFFh and any write to FFFCh asserts data_blocked in that cycle with no select asserted.
- R11: A write with cfg_sel=1 loads the data mode from cfg_wdata[1:0]; the reserved value 2'b10 stores 2'b00.
- R12: A valid fetch asserts exactly one code select; a valid data access asserts exactly one of data_int_sel, data_ext_sel, status_sel, data_blocked; without a valid request none is asserted and status_byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the ROM ceiling field, 1 the data mode field |
| cfg_wdata | input | 8 | Register write data |
| prot_ok | input | 1 | One-cycle protection qualifier for ceiling writes |
| code_pin | input | 1 | Low forces all fetches external |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 16 | Fetch address |
| data_valid | input | 1 | Data access present |
| data_write | input | 1 | Data access is a write |
| data_addr | input | 16 | Data address |
| lock_bits | input | 3 | Lock status to report at FFFCh |
| code_int_sel | output | 1 | Fetch served on chip |
| code_ext_sel | output | 1 | Fetch goes to external bus |
| data_int_sel | output | 1 | Data access served by on-chip SRAM |
| data_ext_sel | output | 1 | Data access goes to external bus |
| status_sel | output | 1 | Lock-status read is being returned |
| status_byte | output | 8 | Lock-status byte |
| data_blocked | output | 1 | Data access dropped |
| rom_size_q | output | 3 | Held ceiling code |
| data_mode_q | output | 2 | Held data mode |

## Verification
The bench targets each ceiling boundary from both sides, since an off-by-one compare would send the last internal word outside or the first external word inside. It probes the reserved top addresses in the mapped mode, where a wrong decoder would leak FFFDh–FFFFh or a FFFCh write onto the external bus, or return the status byte on the wrong address. It tries unprotected and reserved-value writes, which a careless register would accept verbatim, leaving a ceiling of 110 or a mode of 10 that decodes to nothing. The code pin is driven low against a large ceiling to show the override wins.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned SZ_W = 3;
  localparam int unsigned DM_W = 2;
  localparam logic [SZ_W-1:0] SZ_RESET = 3'b101;
  localparam logic [SZ_W-1:0] SZ_MAX_LEGAL = 3'b101;

  typedef enum logic [DM_W-1:0] {
    DM_ALL_EXT  = 2'b00,
    DM_LOW_SRAM = 2'b01,
    DM_RESERVED = 2'b10,
    DM_LOCK_MAP = 2'b11
  } dmode_e;

  // Reserved ceiling codes fold onto the full-size setting.
  function automatic logic [SZ_W-1:0] clean_size(input logic [SZ_W-1:0] v);
    return (v > SZ_MAX_LEGAL) ? SZ_RESET : v;
  endfunction

  // Reserved data mode folds onto the all-external setting.
  function automatic dmode_e clean_mode(input logic [DM_W-1:0] v);
    return (dmode_e'(v) == DM_RESERVED) ? DM_ALL_EXT : dmode_e'(v);
  endfunction
endpackage

// File: rtl/mmd_cfg_regs.sv
module mmd_cfg_regs
  import mmd_pkg::*;
#(
  parameter int unsigned WD_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [WD_W-1:0] cfg_wdata,
  input  logic            prot_ok,
  output logic [SZ_W-1:0] size_q,
  output dmode_e          mode_q
);
  logic size_we;
  logic mode_we;

  assign size_we = cfg_wr && !cfg_sel && prot_ok;
  assign mode_we = cfg_wr && cfg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_RESET;
    end else if (size_we) begin
      size_q <= clean_size(cfg_wdata[SZ_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DM_ALL_EXT;
    end else if (mode_we) begin
      mode_q <= clean_mode(cfg_wdata[DM_W-1:0]);
    end
  end
endmodule

// File: rtl/mmd_code_decode.sv
module mmd_code_decode
  import mmd_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned BASE_LOG2 = 10
) (
  input  logic            fetch_valid,
  input  logic [AW-1:0]   fetch_addr,
  input  logic            code_pin,
  input  logic [SZ_W-1:0] size_q,
  output logic            int_sel,
  output logic            ext_sel
);
  localparam int unsigned LW = AW + 1;

  logic [LW-1:0] limit_excl;
  logic          below_limit;
  logic          size_zero;

  always_comb begin
    if (size_q == '0) begin
      limit_excl = '0;
    end else begin
      limit_excl = LW'(1) << (BASE_LOG2 + 32'(size_q) - 1);
    end
  end

  assign size_zero   = (size_q == '0);
  assign below_limit = ({1'b0, fetch_addr} < limit_excl);
  assign int_sel     = fetch_valid && code_pin && !size_zero && below_limit;
  assign ext_sel     = fetch_valid && !int_sel;
endmodule

// File: rtl/mmd_data_decode.sv
module mmd_data_decode
  import mmd_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned SRAM_BYTES = 1024,
  parameter int unsigned LOCK_W     = 3,
  parameter int unsigned STAT_W     = 8
) (
  input  logic              data_valid,
  input  logic              data_write,
  input  logic [AW-1:0]     data_addr,
  input  logic [LOCK_W-1:0] lock_bits,
  input  dmode_e            mode_q,
  output logic              int_sel,
  output logic              ext_sel,
  output logic              stat_sel,
  output logic [STAT_W-1:0] stat_byte,
  output logic              blocked
);
  localparam logic [AW-1:0] TOP_ADDR  = '1;
  localparam logic [AW-1:0] STAT_ADDR = TOP_ADDR - AW'(3);
  localparam logic [AW:0]   SRAM_LIM  = (AW+1)'(SRAM_BYTES);

  logic in_sram;
  logic in_reserved;
  logic at_status;

  assign in_sram     = ({1'b0, data_addr} < SRAM_LIM);
  assign in_reserved = (data_addr >= STAT_ADDR);
  assign at_status   = (data_addr == STAT_ADDR);

  always_comb begin
    int_sel  = 1'b0;
    ext_sel  = 1'b0;
    stat_sel = 1'b0;
    blocked  = 1'b0;
    if (data_valid) begin
      unique case (mode_q)
        DM_LOW_SRAM: begin
          int_sel = in_sram;
          ext_sel = !in_sram;
        end
        DM_LOCK_MAP: begin
          if (in_sram) begin
            int_sel = 1'b1;
          end else if (!in_reserved) begin
            ext_sel = 1'b1;
          end else if (at_status && !data_write) begin
            stat_sel = 1'b1;
          end else begin
            blocked = 1'b1;
          end
        end
        default: ext_sel = 1'b1;
      endcase
    end
  end

  assign stat_byte = stat_sel ? STAT_W'(lock_bits) : '0;
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import mmd_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned WD_W       = 8,
  parameter int unsigned BASE_LOG2  = 10,
  parameter int unsigned SRAM_BYTES = 1024,
  parameter int unsigned LOCK_W     = 3,
  parameter int unsigned STAT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [WD_W-1:0]   cfg_wdata,
  input  logic              prot_ok,
  input  logic              code_pin,
  input  logic              fetch_valid,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              data_valid,
  input  logic              data_write,
  input  logic [AW-1:0]     data_addr,
  input  logic [LOCK_W-1:0] lock_bits,
  output logic              code_int_sel,
  output logic              code_ext_sel,
  output logic              data_int_sel,
  output logic              data_ext_sel,
  output logic              status_sel,
  output logic [STAT_W-1:0] status_byte,
  output logic              data_blocked,
  output logic [SZ_W-1:0]   rom_size_q,
  output logic [DM_W-1:0]   data_mode_q
);
  logic [SZ_W-1:0] size_w;
  dmode_e          mode_w;

  mmd_cfg_regs #(.WD_W(WD_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .prot_ok   (prot_ok),
    .size_q    (size_w),
    .mode_q    (mode_w)
  );

  mmd_code_decode #(.AW(AW), .BASE_LOG2(BASE_LOG2)) u_code (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .code_pin    (code_pin),
    .size_q      (size_w),
    .int_sel     (code_int_sel),
    .ext_sel     (code_ext_sel)
  );

  mmd_data_decode #(
    .AW(AW), .SRAM_BYTES(SRAM_BYTES), .LOCK_W(LOCK_W), .STAT_W(STAT_W)
  ) u_data (
    .data_valid (data_valid),
    .data_write (data_write),
    .data_addr  (data_addr),
    .lock_bits  (lock_bits),
    .mode_q     (mode_w),
    .int_sel    (data_int_sel),
    .ext_sel    (data_ext_sel),
    .stat_sel   (status_sel),
    .stat_byte  (status_byte),
    .blocked    (data_blocked)
  );

  assign rom_size_q  = size_w;
  assign data_mode_q = mode_w;
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker #(
  parameter int unsigned AW     = 16,
  parameter int unsigned WD_W   = 8,
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_sel,
  input logic              prot_ok,
  input logic              code_pin,
  input logic              fetch_valid,
  input logic              data_valid,
  input logic              data_write,
  input logic [AW-1:0]     data_addr,
  input logic              code_int_sel,
  input logic              code_ext_sel,
  input logic              data_int_sel,
  input logic              data_ext_sel,
  input logic              status_sel,
  input logic [STAT_W-1:0] status_byte,
  input logic              data_blocked,
  input logic [2:0]        rom_size_q,
  input logic [1:0]        data_mode_q
);
  logic [3:0] data_outs;
  assign data_outs = {data_int_sel, data_ext_sel, status_sel, data_blocked};

  assert_code_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $countones({code_int_sel, code_ext_sel}) == 1);

  assert_data_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $countones(data_outs) == 1);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !data_valid) |-> (!code_int_sel && !code_ext_sel && data_outs == '0));

  assert_pin_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !code_pin) |-> code_ext_sel);

  assert_plain_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && !prot_ok) |=> $stable(rom_size_q));

  assert_size_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_size_q <= 3'b101);

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_mode_q != 2'b10);

  assert_sram_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_int_sel |-> (data_addr < AW'(1024)));

  assert_status_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_sel |-> (!data_write && data_mode_q == 2'b11 && status_byte[STAT_W-1:3] == '0));

  assert_blocked_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_blocked |-> (data_mode_q == 2'b11 && data_addr >= (AW'(0) - AW'(4))));
endmodule

bind memmap_decoder mmd_checker #(.AW(AW), .WD_W(WD_W), .STAT_W(STAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_sel      (cfg_sel),
  .prot_ok      (prot_ok),
  .code_pin     (code_pin),
  .fetch_valid  (fetch_valid),
  .data_valid   (data_valid),
  .data_write   (data_write),
  .data_addr    (data_addr),
  .code_int_sel (code_int_sel),
  .code_ext_sel (code_ext_sel),
  .data_int_sel (data_int_sel),
  .data_ext_sel (data_ext_sel),
  .status_sel   (status_sel),
  .status_byte  (status_byte),
  .data_blocked (data_blocked),
  .rom_size_q   (rom_size_q),
  .data_mode_q  (data_mode_q)
);

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 0, cfg_sel = 0, prot_ok = 0, code_pin = 1;
  logic [7:0]  cfg_wdata = 0;
  logic        fetch_valid = 0, data_valid = 0, data_write = 0;
  logic [15:0] fetch_addr = 0, data_addr = 0;
  logic [2:0]  lock_bits = 0;
  logic        code_int_sel, code_ext_sel, data_int_sel, data_ext_sel;
  logic        status_sel, data_blocked;
  logic [7:0]  status_byte;
  logic [2:0]  rom_size_q;
  logic [1:0]  data_mode_q;

  int errors = 0;
  int checks = 0;
  int m_size;
  int m_mode;
  bit done = 0;

  always #5 clk = ~clk;

  memmap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .prot_ok(prot_ok), .code_pin(code_pin),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .data_valid(data_valid), .data_write(data_write), .data_addr(data_addr),
    .lock_bits(lock_bits), .code_int_sel(code_int_sel),
    .code_ext_sel(code_ext_sel), .data_int_sel(data_int_sel),
    .data_ext_sel(data_ext_sel), .status_sel(status_sel),
    .status_byte(status_byte), .data_blocked(data_blocked),
    .rom_size_q(rom_size_q), .data_mode_q(data_mode_q)
  );

  // Expected output vector: {ci, ce, di, de, st, bl, status[7:0], size[2:0], mode[1:0]}
  function automatic logic [18:0] expect_vec();
    logic ci, ce, di, de, st, bl;
    logic [7:0] sb;
    int bytes;
    bytes = 512 << m_size;
    ci = fetch_valid && code_pin && m_size != 0 && int'(fetch_addr) < bytes;
    ce = fetch_valid && !ci;
    di = 0; de = 0; st = 0; bl = 0; sb = 0;
    if (data_valid) begin
      if (m_mode == 1) begin
        if (data_addr < 16'h0400) di = 1; else de = 1;
      end else if (m_mode == 3) begin
        if (data_addr < 16'h0400) di = 1;
        else if (data_addr <= 16'hFFFB) de = 1;
        else if (data_addr == 16'hFFFC && !data_write) begin
          st = 1; sb = {5'b00000, lock_bits};
        end else bl = 1;
      end else de = 1;
    end
    return {ci, ce, di, de, st, bl, sb, 3'(m_size), 2'(m_mode)};
  endfunction

  task automatic compare(input string tag);
    logic [18:0] got, exp;
    got = {code_int_sel, code_ext_sel, data_int_sel, data_ext_sel, status_sel,
           data_blocked, status_byte, rom_size_q, data_mode_q};
    exp = expect_vec();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: fa=%h da=%h got=%b expected=%b", tag, fetch_addr, data_addr, got, exp);
    end
  endtask

  // One cycle: drive after negedge, check before posedge, advance model at posedge.
  task automatic cyc(input string tag);
    #1 compare(tag);
    @(posedge clk);
    if (rst_n && cfg_wr && !cfg_sel && prot_ok)
      m_size = (cfg_wdata[2:0] > 3'd5) ? 5 : int'(cfg_wdata[2:0]);
    if (rst_n && cfg_wr && cfg_sel)
      m_mode = (cfg_wdata[1:0] == 2'b10) ? 0 : int'(cfg_wdata[1:0]);
    @(negedge clk);
    cfg_wr = 0; prot_ok = 0; fetch_valid = 0; data_valid = 0; data_write = 0;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] v, input logic prot, input string tag);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = v; prot_ok = prot;
    cyc(tag);
  endtask

  task automatic fetch(input logic [15:0] a, input string tag);
    fetch_valid = 1; fetch_addr = a;
    cyc(tag);
  endtask

  task automatic dacc(input logic [15:0] a, input logic w, input string tag);
    data_valid = 1; data_addr = a; data_write = w;
    cyc(tag);
  endtask

  initial begin
    m_size = 5; m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1 reset state");
    fetch(16'h3FFF, "R2 default last internal");
    fetch(16'h4000, "R2 default first external");
    wr_reg(0, 8'h03, 0, "R5 plain write");
    fetch(16'h1000, "R5 size unchanged after plain write");
    wr_reg(0, 8'h03, 1, "R5 protected write");
    fetch(16'h0FFF, "R2 4k last internal");
    fetch(16'h1000, "R2 4k first external");
    wr_reg(0, 8'h01, 1, "R2 set 1k");
    fetch(16'h03FF, "R2 1k last internal");
    fetch(16'h0400, "R2 1k first external");
    wr_reg(0, 8'h00, 1, "R3 set zero");
    fetch(16'h0000, "R3 zero size external");
    wr_reg(0, 8'h06, 1, "R6 reserved 110");
    fetch(16'h3FFF, "R6 folded to 16k");
    wr_reg(0, 8'h02, 1, "R6 set 2k");
    wr_reg(0, 8'h07, 1, "R6 reserved 111");
    fetch(16'h2000, "R6 folded again");
    code_pin = 0;
    fetch(16'h0000, "R4 pin low forces external");
    code_pin = 1;
    dacc(16'h0000, 0, "R7 mode 00 low address");
    dacc(16'hFFFC, 1, "R7 mode 00 top address");
    wr_reg(1, 8'h01, 0, "R8 set mode 01");
    dacc(16'h03FF, 1, "R8 last sram");
    dacc(16'h0400, 0, "R8 first external");
    dacc(16'hFFFD, 0, "R8 top external");
    wr_reg(1, 8'h02, 0, "R11 reserved mode");
    dacc(16'h0010, 0, "R11 folded to all external");
    wr_reg(1, 8'h03, 0, "R9 set mode 11");
    lock_bits = 3'b101;
    dacc(16'h0400, 0, "R9 first external");
    dacc(16'hFFFB, 1, "R9 last external");
    dacc(16'hFFFC, 0, "R9 status read");
    dacc(16'hFFFC, 1, "R10 status write blocked");
    dacc(16'hFFFD, 0, "R10 FFFD blocked");
    dacc(16'hFFFF, 1, "R10 FFFF blocked");
    cyc("R12 idle");
    for (int i = 0; i < 400; i++) begin
      cfg_wr = ($urandom_range(0, 7) == 0);
      cfg_sel = $urandom_range(0, 1);
      cfg_wdata = 8'($urandom);
      prot_ok = $urandom_range(0, 1);
      code_pin = ($urandom_range(0, 5) != 0);
      fetch_valid = $urandom_range(0, 1);
      fetch_addr = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 16'h4100)) : 16'($urandom);
      data_valid = $urandom_range(0, 1);
      data_write = $urandom_range(0, 1);
      data_addr = ($urandom_range(0, 2) == 0) ? 16'hFFF8 + 16'($urandom_range(0, 7))
                : 16'($urandom_range(0, 16'h0500));
      lock_bits = 3'($urandom);
      cyc("R12 random mix");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, got=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule